// File: doc/BRIEF.md
# Hysteretic Digital Phase-Lock Detector

This block watches the reference and feedback pulse trains that feed a phase detector and reports whether the loop is locked. It samples both pulse trains with a fast counting clock and detects the rising edge of each. For every reference/feedback pair it measures the phase error as the number of fast-clock cycles between the earlier edge and the later one.

Lock is declared only after a run of consecutive comparisons whose error is below a tight set threshold. A precision-select input picks the length of that run. Once declared, lock is held until a comparison shows an error at or above a wider clear threshold. The gap between the two thresholds stops the flag from chattering when the error sits near the tolerance.

Both thresholds are parameters given in fast-clock cycles. They are sized from the nanosecond tolerances and the counting clock period. A reference edge that repeats before its feedback edge arrives is treated as a gross error, and so is a feedback edge that repeats before its reference edge.

Top module: `pll_lock_detect`

## Requirements
- R1: A synchronous active-high reset clears the lock flag to 0 and the consecutive-good run count to 0.
- R2: The phase error of one comparison is the number of fast-clock cycles between the rising edge of one input and the rising edge of the other input. The result is the same whichever input leads. Two edges in the same cycle give an error of 0.
- R3: A comparison is good when its error is strictly below SET_THR (default 4). With `prec_sel` = 0, the lock flag rises after 3 consecutive good comparisons.
- R4: With `prec_sel` = 1, the lock flag rises after 5 consecutive good comparisons.
- R5: While unlocked, a comparison with error at or above SET_THR resets the run count to 0, so a new full run is required.
- R6: While locked, a comparison with error below CLR_THR (default 7) leaves the flag high. This includes errors in the band from SET_THR to CLR_THR-1.
- R7: While locked, a comparison with error at or above CLR_THR drops the flag to 0.
- R8: A second rising edge on the leading input before the other input has produced an edge closes the comparison with an error at or above CLR_THR. The new edge then opens the next comparison.
- R9: `locked` is active high. It changes only in the cycle after a completed comparison has been registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast counting clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference pulse train, synchronous to clk |
| fb_in | input | 1 | Divided feedback pulse train, synchronous to clk |
| prec_sel | input | 1 | Run length select: 0 selects 3 comparisons, 1 selects 5 |
| locked | output | 1 | Lock flag, active high |

## Verification
The comparisons are driven at offsets of 0 to 3 cycles, which are good. They are also driven in the hysteresis band of 4 to 6 cycles and at gross errors of 7 cycles or more. Both the reference and the feedback input are made to lead. Short runs that stop one comparison short of the needed length tell the 3-count mode apart from the 5-count mode. A band error placed inside a run shows that the run count restarts. Band errors while locked show that the flag holds. A repeated reference pulse with no feedback pulse shows that a missing edge is treated as a gross error, and a reset applied while locked shows that both the flag and the run count are cleared.

// File: rtl/pll_lock_detect_pkg.sv
package pll_lock_detect_pkg;

    // Width of the phase-error count; the all-ones value marks a missing edge.
    localparam int ERR_W = 8;
    localparam logic [ERR_W-1:0] ERR_MISS = '1;

    typedef enum logic {
        SIDE_REF = 1'b0,
        SIDE_FB  = 1'b1
    } lead_side_e;

    typedef struct packed {
        logic             valid;
        logic [ERR_W-1:0] err;
    } phase_meas_t;

    function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v);
        return (v == ERR_MISS) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pld_rise_detect.sv
module pld_rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pulse_in;
    end

    assign rise = pulse_in & ~prev_q;
endmodule

// File: rtl/pld_phase_meter.sv
module pld_phase_meter
    import pll_lock_detect_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_rise,
    input  logic        fb_rise,
    output phase_meas_t meas
);
    logic             busy_q;
    lead_side_e       lead_q;
    logic [ERR_W-1:0] cnt_q;
    phase_meas_t      meas_q;

    logic lead_again;
    logic other_seen;

    // Edge from the same side as the one that opened the window.
    assign lead_again = (lead_q == SIDE_REF) ? ref_rise : fb_rise;
    // Edge from the side the window is waiting for.
    assign other_seen = (lead_q == SIDE_REF) ? fb_rise  : ref_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            lead_q <= SIDE_REF;
            cnt_q  <= '0;
            meas_q <= '0;
        end else begin
            meas_q.valid <= 1'b0;
            if (!busy_q) begin
                if (ref_rise && fb_rise) begin
                    meas_q.valid <= 1'b1;
                    meas_q.err   <= '0;
                end else if (ref_rise || fb_rise) begin
                    busy_q <= 1'b1;
                    lead_q <= ref_rise ? SIDE_REF : SIDE_FB;
                    cnt_q  <= {{(ERR_W-1){1'b0}}, 1'b1};
                end
            end else if (lead_again) begin
                // Leading side fired again: the awaited edge never came.
                meas_q.valid <= 1'b1;
                meas_q.err   <= ERR_MISS;
                if (other_seen) begin
                    busy_q <= 1'b0;
                end else begin
                    cnt_q <= {{(ERR_W-1){1'b0}}, 1'b1};
                end
            end else if (other_seen) begin
                meas_q.valid <= 1'b1;
                meas_q.err   <= cnt_q;
                busy_q       <= 1'b0;
            end else begin
                cnt_q <= sat_inc(cnt_q);
            end
        end
    end

    assign meas = meas_q;
endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm
    import pll_lock_detect_pkg::*;
#(
    parameter int SET_THR = 4,
    parameter int CLR_THR = 7,
    parameter int RUN_LO  = 3,
    parameter int RUN_HI  = 5,
    localparam int RUN_MAX = (RUN_HI > RUN_LO) ? RUN_HI : RUN_LO,
    localparam int RUN_W   = $clog2(RUN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prec_sel,
    input  phase_meas_t      meas,
    output logic             locked,
    output logic [RUN_W-1:0] run_cnt
);
    localparam logic [ERR_W-1:0] SET_C = ERR_W'(SET_THR);
    localparam logic [ERR_W-1:0] CLR_C = ERR_W'(CLR_THR);
    localparam logic [RUN_W-1:0] NEED_LO = RUN_W'(RUN_LO);
    localparam logic [RUN_W-1:0] NEED_HI = RUN_W'(RUN_HI);

    logic             locked_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] run_inc;
    logic             is_good;
    logic             is_bad;

    assign need    = prec_sel ? NEED_HI : NEED_LO;
    assign run_inc = run_q + 1'b1;
    assign is_good = meas.err < SET_C;
    assign is_bad  = meas.err >= CLR_C;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            run_q    <= '0;
        end else if (meas.valid) begin
            if (!locked_q) begin
                if (!is_good) begin
                    run_q <= '0;
                end else if (run_inc >= need) begin
                    locked_q <= 1'b1;
                    run_q    <= '0;
                end else begin
                    run_q <= run_inc;
                end
            end else if (is_bad) begin
                locked_q <= 1'b0;
                run_q    <= '0;
            end
        end
    end

    assign locked  = locked_q;
    assign run_cnt = run_q;
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import pll_lock_detect_pkg::*;
#(
    parameter int SET_THR = 4,
    parameter int CLR_THR = 7,
    parameter int RUN_LO  = 3,
    parameter int RUN_HI  = 5,
    localparam int RUN_MAX = (RUN_HI > RUN_LO) ? RUN_HI : RUN_LO,
    localparam int RUN_W   = $clog2(RUN_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    input  logic prec_sel,
    output logic locked
);
    logic [1:0]       rise;
    logic [1:0]       raw;
    phase_meas_t      meas;
    logic [RUN_W-1:0] run_cnt;

    assign raw = {fb_in, ref_in};

    for (genvar g = 0; g < 2; g++) begin : g_edge
        pld_rise_detect u_rise (
            .clk      (clk),
            .rst      (rst),
            .pulse_in (raw[g]),
            .rise     (rise[g])
        );
    end

    pld_phase_meter u_meter (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (rise[0]),
        .fb_rise  (rise[1]),
        .meas     (meas)
    );

    pld_lock_fsm #(
        .SET_THR (SET_THR),
        .CLR_THR (CLR_THR),
        .RUN_LO  (RUN_LO),
        .RUN_HI  (RUN_HI)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .prec_sel (prec_sel),
        .meas     (meas),
        .locked   (locked),
        .run_cnt  (run_cnt)
    );
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk #(
    parameter int ERR_W   = 8,
    parameter int RUN_W   = 3,
    parameter int SET_THR = 4,
    parameter int CLR_THR = 7,
    parameter int RUN_MAX = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             locked,
    input logic             meas_valid,
    input logic [ERR_W-1:0] meas_err,
    input logic [RUN_W-1:0] run_cnt
);
    localparam logic [ERR_W-1:0] SET_C = ERR_W'(SET_THR);
    localparam logic [ERR_W-1:0] CLR_C = ERR_W'(CLR_THR);
    localparam logic [RUN_W-1:0] RMAX  = RUN_W'(RUN_MAX);

    // R1: reset leaves flag and run count cleared
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!locked && run_cnt == '0));

    // R3: lock only rises after a registered good comparison
    assert_rise_after_good_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(meas_valid && meas_err < SET_C));

    // R5: an out-of-tolerance comparison while unlocked restarts the run
    assert_run_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (!locked && meas_valid && meas_err >= SET_C) |=> (run_cnt == '0));

    // R6: errors below the clear threshold keep lock
    assert_hold_in_band_R6: assert property (@(posedge clk) disable iff (rst)
        (locked && !(meas_valid && meas_err >= CLR_C)) |=> locked);

    // R7: lock only falls after a gross error
    assert_fall_after_bad_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(meas_valid && meas_err >= CLR_C));

    // R4: run count never reaches the longest run length
    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        run_cnt < RMAX);
endmodule

bind pll_lock_detect pll_lock_detect_chk #(
    .ERR_W   (pll_lock_detect_pkg::ERR_W),
    .RUN_W   (RUN_W),
    .SET_THR (SET_THR),
    .CLR_THR (CLR_THR),
    .RUN_MAX (RUN_MAX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .locked     (locked),
    .meas_valid (meas.valid),
    .meas_err   (meas.err),
    .run_cnt    (run_cnt)
);

// File: tb/pll_lock_detect_bench.sv
module pll_lock_detect_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic prec_sel = 1'b0;
    logic locked;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pll_lock_detect u_pll_lock_detect (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (ref_in),
        .fb_in    (fb_in),
        .prec_sel (prec_sel),
        .locked   (locked)
    );

    // {prec_sel, fb leads, offset, count, expected locked}
    localparam int NV = 12;
    localparam logic [10:0] VECS [NV] = '{
        {1'b0, 1'b0, 4'd2, 4'd2, 1'b0},  // R3 run of 2 short
        {1'b0, 1'b1, 4'd3, 4'd1, 1'b1},  // R3 R2 third good, fb leads
        {1'b0, 1'b0, 4'd5, 4'd3, 1'b1},  // R6 band holds
        {1'b0, 1'b1, 4'd7, 4'd1, 1'b0},  // R7 gross error
        {1'b1, 1'b0, 4'd0, 4'd4, 1'b0},  // R4 R2 coincident, 4 short
        {1'b1, 1'b1, 4'd1, 4'd1, 1'b1},  // R4 fifth good
        {1'b1, 1'b0, 4'd6, 4'd2, 1'b1},  // R6 band edge holds
        {1'b1, 1'b0, 4'd9, 4'd1, 1'b0},  // R7 large error
        {1'b1, 1'b0, 4'd3, 4'd3, 1'b0},  // R4 partial run
        {1'b1, 1'b1, 4'd4, 4'd1, 1'b0},  // R5 band restarts run
        {1'b1, 1'b0, 4'd3, 4'd4, 1'b0},  // R5 4 since restart
        {1'b1, 1'b0, 4'd2, 4'd1, 1'b1}   // R5 fifth since restart
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: locked=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One comparison: leader pulse, follower pulse off cycles later.
    task automatic compare(input logic fb_lead, input int off);
        @(negedge clk);
        if (fb_lead) fb_in = 1'b1; else ref_in = 1'b1;
        if (off == 0) begin ref_in = 1'b1; fb_in = 1'b1; end
        @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        if (off > 0) begin
            for (int i = 1; i < off; i++) @(negedge clk);
            if (fb_lead) ref_in = 1'b1; else fb_in = 1'b1;
            @(negedge clk);
            ref_in = 1'b0; fb_in = 1'b0;
        end
        idle(6);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        n_run++;
        $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        idle(3);
        check(locked, 1'b0, "R1 reset state");
        rst = 1'b0;
        idle(2);

        for (int v = 0; v < NV; v++) begin
            prec_sel = VECS[v][10];
            for (int k = 0; k < int'(VECS[v][4:1]); k++)
                compare(VECS[v][9], int'(VECS[v][8:5]));
            check(locked, VECS[v][0], $sformatf("R3/R4/R5/R6/R7 vector %0d", v));
        end

        // R9: flag changes exactly one cycle after the comparison result
        prec_sel = 1'b0;
        rst = 1'b1; idle(2); rst = 1'b0; idle(2);
        compare(1'b0, 1); compare(1'b0, 1);
        @(negedge clk); ref_in = 1'b1; fb_in = 1'b1;
        @(negedge clk); ref_in = 1'b0; fb_in = 1'b0;
        // edge seen at posedge A, result at A, flag at A+1
        check(locked, 1'b0, "R9 not yet");
        @(negedge clk);
        check(locked, 1'b1, "R9 one cycle after result");
        idle(4);

        // R8: repeated reference with no feedback while locked
        @(negedge clk); ref_in = 1'b1;
        @(negedge clk); ref_in = 1'b0;
        idle(3);
        @(negedge clk); ref_in = 1'b1;
        @(negedge clk); ref_in = 1'b0;
        idle(2);
        check(locked, 1'b0, "R8 missing feedback edge");
        // close the open window cleanly with a gross-error follower edge
        idle(10);
        @(negedge clk); fb_in = 1'b1;
        @(negedge clk); fb_in = 1'b0;
        idle(4);

        // R1: reset while locked clears the flag and the run
        compare(1'b0, 0); compare(1'b0, 0); compare(1'b0, 0);
        check(locked, 1'b1, "R1 relock before reset");
        compare(1'b0, 8);
        compare(1'b0, 0); compare(1'b0, 0);
        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        check(locked, 1'b0, "R1 reset clears flag");
        compare(1'b0, 0);
        check(locked, 1'b0, "R1 run cleared by reset");
        compare(1'b0, 0); compare(1'b0, 0);
        check(locked, 1'b1, "R1 full run after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule